// File: doc/BRIEF.md
# Four-Phase Interlocked Bus Transfer Unit

This block carries one word between a requesting agent and a small storage target over a bus whose cycle length is set by a request strobe and an acknowledge strobe, not by a count of clock cycles. An initiator state machine takes a request from its agent. It drives address, select and a read flag onto the bus, and then raises the request strobe. A target state machine sees the strobe through a two-flop synchronizer and performs the access. When the access is done it raises the acknowledge. The initiator then drops its strobe, the target drops its acknowledge, and the initiator reports completion. Each side reads the other's strobe only through its own synchronizer, so the two could run from unrelated clocks.

The agent side is a valid/ready port. The agent raises `req_valid` with `req_wr`, `req_addr` and `req_wdata` and holds them stable until it sees `req_ready` high at a rising edge. `req_ready` stays low for the whole transfer, which is the only form of back-pressure. Completion is a one-cycle `done` pulse that cannot be stalled. On a read, `rdata` holds the returned word from `done` until the next read completes. The target is a register array whose access time is set by the parameter `RESP_DELAY`. A slower target lengthens the transfer by the extra cycles, with nothing else changed.

Top module: `hs_bus_top`

## Requirements
- R1: After reset `bus_stb`, `bus_ack`, `bus_sel` and `done` are 0, `req_ready` is 1, and every storage word reads as 0.
- R2: `bus_addr`, `bus_rd` and `bus_sel`=1 are driven at least one cycle before `bus_stb` rises. They stay stable while `bus_stb` is high, and `bus_sel` falls in the same cycle as `bus_stb`.
- R3: The target raises `bus_ack` only after it has seen `bus_stb` high through its synchronizer, and only after `RESP_DELAY` access cycles.
- R4: The initiator lowers `bus_stb` only after it has seen `bus_ack` high through its synchronizer, so `bus_ack` is high whenever `bus_stb` falls.
- R5: The target lowers `bus_ack` only after it has seen `bus_stb` low. While `bus_ack` is high the read data it drives stays stable.
- R6: `done` is a single-cycle pulse that follows the fall of `bus_ack`. `req_ready` is 0 from the accepting edge until `done` has been raised, and a request held during that time is not taken.
- R7: A write (`req_wr`=1) stores `req_wdata` at `req_addr`. A read (`req_wr`=0) returns the last word written to that address on `rdata` when `done` is high. Addresses 0 and 2^ADDR_W-1 both work.
- R8: The transfer length, from the accepting edge to `done`, grows by exactly the difference in `RESP_DELAY` between two instances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Agent request valid |
| req_ready | output | 1 | Initiator idle and accepting |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read result, valid with done on reads |
| bus_stb | output | 1 | Bus request strobe (initiator to target) |
| bus_ack | output | 1 | Bus acknowledge strobe (target to initiator) |
| bus_sel | output | 1 | Bus memory select |
| bus_rd | output | 1 | Bus read flag |
| bus_addr | output | ADDR_W | Bus address |

## Verification
The assertions check the interlock on every cycle. Address and select must be ready before the strobe and stay stable while it is high. Each strobe edge must follow the synchronized level of the opposite strobe. Read data must hold while acknowledge is high, and `done` must be a single pulse. The bench scenarios cover what a single cycle cannot show: data written and then read back at the edge addresses, a request refused while a transfer is in flight, and the transfer length of a slow target compared with a fast one.

// File: rtl/hs_bus_pkg.sv
package hs_bus_pkg;
  typedef enum logic [1:0] {
    INI_IDLE  = 2'd0,
    INI_SETUP = 2'd1,
    INI_WAIT  = 2'd2,
    INI_REL   = 2'd3
  } ini_state_t;

  typedef enum logic [1:0] {
    TGT_IDLE = 2'd0,
    TGT_BUSY = 2'd1,
    TGT_ACK  = 2'd2
  } tgt_state_t;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hs_initiator.sv
module hs_initiator
  import hs_bus_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_sel,
  output logic              bus_rd,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_stb,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  ini_state_t st;
  logic       ack_s;

  hs_sync2 #(.STAGES(2)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_ack), .dout(ack_s)
  );

  assign req_ready = (st == INI_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= INI_IDLE;
      done      <= 1'b0;
      rdata     <= '0;
      bus_addr  <= '0;
      bus_sel   <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wdata <= '0;
      bus_stb   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        INI_IDLE: if (req_valid) begin
          bus_addr  <= req_addr;
          bus_rd    <= ~req_wr;
          bus_wdata <= req_wdata;
          bus_sel   <= 1'b1;
          st        <= INI_SETUP;
        end
        INI_SETUP: begin
          bus_stb <= 1'b1;
          st      <= INI_WAIT;
        end
        INI_WAIT: if (ack_s) begin
          if (bus_rd) rdata <= bus_rdata;
          bus_stb <= 1'b0;
          bus_sel <= 1'b0;
          st      <= INI_REL;
        end
        INI_REL: if (!ack_s) begin
          done <= 1'b1;
          st   <= INI_IDLE;
        end
        default: st <= INI_IDLE;
      endcase
    end
  end

  // R2
  addr_before_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_stb) |-> ($past(bus_sel) && bus_sel));
  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && $past(bus_stb)) |-> ($stable(bus_addr) && $stable(bus_rd) && bus_sel));
  // R4
  stb_fall_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_stb) |-> $past(ack_s));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_after_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!$past(ack_s) && !bus_stb));
endmodule

// File: rtl/hs_target.sv
module hs_target
  import hs_bus_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int RESP_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_stb,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = (RESP_DELAY < 2) ? 1 : $clog2(RESP_DELAY);
  localparam logic [CNT_W-1:0] CNT_LOAD = (RESP_DELAY > 0) ? CNT_W'(RESP_DELAY - 1) : '0;

  tgt_state_t        st;
  logic              stb_s;
  logic [CNT_W-1:0]  cnt;
  logic              fire;
  logic [DATA_W-1:0] mem [DEPTH];

  hs_sync2 #(.STAGES(2)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_stb), .dout(stb_s)
  );

  generate
    if (RESP_DELAY == 0) begin : g_instant
      assign fire = (st == TGT_IDLE) && stb_s && bus_sel;
    end else begin : g_delayed
      assign fire = (st == TGT_BUSY) && (cnt == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= TGT_IDLE;
      cnt       <= '0;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (fire) begin
        if (bus_rd) bus_rdata     <= mem[bus_addr];
        else        mem[bus_addr] <= bus_wdata;
        bus_ack <= 1'b1;
        st      <= TGT_ACK;
      end else begin
        unique case (st)
          TGT_IDLE: if (stb_s && bus_sel) begin
            cnt <= CNT_LOAD;
            st  <= TGT_BUSY;
          end
          TGT_BUSY: cnt <= cnt - 1'b1;
          TGT_ACK: if (!stb_s) begin
            bus_ack <= 1'b0;
            st      <= TGT_IDLE;
          end
          default: st <= TGT_IDLE;
        endcase
      end
    end
  end

  // R3
  ack_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(stb_s));
  // R5
  ack_fall_after_stb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> !$past(stb_s));
  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && $past(bus_ack)) |-> $stable(bus_rdata));
endmodule

// File: rtl/hs_bus_top.sv
module hs_bus_top #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int RESP_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_stb,
  output logic              bus_ack,
  output logic              bus_sel,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr
);
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;

  hs_initiator #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ini (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_stb(bus_stb),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  hs_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESP_DELAY(RESP_DELAY)) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_stb(bus_stb),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );
endmodule

// File: tb/hs_bus_top_tb_top.sv
module hs_bus_top_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int D_FAST = 2;
  localparam int D_SLOW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic          req_valid = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done, bus_stb, bus_ack, bus_sel, bus_rd;
  logic [DW-1:0] rdata;
  logic [AW-1:0] bus_addr;

  hs_bus_top #(.ADDR_W(AW), .DATA_W(DW), .RESP_DELAY(D_FAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_stb(bus_stb), .bus_ack(bus_ack),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr)
  );

  logic          s_valid = 1'b0;
  logic          s_ready, s_done, s_stb, s_ack, s_sel, s_rd;
  logic [DW-1:0] s_rdata;
  logic [AW-1:0] s_addr;

  hs_bus_top #(.ADDR_W(AW), .DATA_W(DW), .RESP_DELAY(D_SLOW)) dut_slow_i (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
    .req_wr(1'b0), .req_addr(4'd5), .req_wdata(16'h0),
    .done(s_done), .rdata(s_rdata), .bus_stb(s_stb), .bus_ack(s_ack),
    .bus_sel(s_sel), .bus_rd(s_rd), .bus_addr(s_addr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { bit wr; logic [DW-1:0] data; } exp_t;
  exp_t          sb_q[$];
  logic [DW-1:0] model [1<<AW];
  int            t_acc = 0;
  int            last_lat = 0;
  bit            prev_stb = 0, prev_ack = 0, prev_done = 0;

  // monitor: scoreboard plus bus ordering
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_stb && !prev_stb) check(bus_sel == 1'b1, "R2 sel with stb rise", bus_sel, 1);
      if (!bus_stb && prev_stb) check(bus_ack == 1'b1, "R4 ack high at stb fall", bus_ack, 1);
      if (bus_ack && !prev_ack) check(bus_stb == 1'b1, "R3 stb high at ack rise", bus_stb, 1);
      if (!bus_ack && prev_ack) check(bus_stb == 1'b0, "R5 stb low at ack fall", bus_stb, 0);
      if (done && prev_done)    check(1'b0, "R6 done width", 2, 1);
      if (done) begin
        last_lat = cyc - t_acc;
        if (sb_q.size() == 0) check(1'b0, "R7 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          if (!e.wr) check(rdata == e.data, "R7 read data", rdata, e.data);
        end
      end
      prev_stb  = bus_stb;
      prev_ack  = bus_ack;
      prev_done = done;
    end
  end

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    t_acc = cyc;
    req_valid = 1'b0;
    if (wr) model[a] = d;
    e.wr = wr; e.data = model[a];
    sb_q.push_back(e);
    @(negedge clk);
    check(req_ready == 1'b0, "R6 ready low in flight", req_ready, 0);
    do @(negedge clk); while (!done);
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat_fast, lat_slow, t0;
    for (int i = 0; i < (1<<AW); i++) model[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(bus_stb == 0 && bus_ack == 0 && bus_sel == 0 && done == 0, "R1 bus idle in reset",
          {bus_stb, bus_ack, bus_sel, done}, 0);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fresh storage reads zero
    xfer(1'b0, 4'd7, '0);
    xfer(1'b1, 4'd0, 16'hA5A5);
    xfer(1'b1, 4'd15, 16'h3C0F);
    xfer(1'b1, 4'd9, 16'h1234);
    xfer(1'b0, 4'd0, '0);
    xfer(1'b0, 4'd15, '0);
    xfer(1'b0, 4'd9, '0);
    xfer(1'b1, 4'd9, 16'hFFFF);
    xfer(1'b0, 4'd9, '0);

    // R6: request held during a transfer is not taken
    begin
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_wr = 1'b1; req_addr = 4'd3; req_wdata = 16'hBEEF;
      @(posedge clk); #1;
      t_acc = cyc;
      model[3] = 16'hBEEF;
      e.wr = 1'b1; e.data = '0; sb_q.push_back(e);
      req_wdata = 16'hDEAD; req_addr = 4'd4;
      repeat (5) begin
        @(negedge clk);
        check(req_ready == 1'b0, "R6 held request refused", req_ready, 0);
      end
      req_valid = 1'b0;
      do @(negedge clk); while (!done);
    end
    xfer(1'b0, 4'd4, '0);
    xfer(1'b0, 4'd3, '0);

    // R8: latency tracks target delay
    xfer(1'b0, 4'd5, '0);
    lat_fast = last_lat;
    @(negedge clk);
    s_valid = 1'b1;
    @(posedge clk); #1;
    t0 = cyc;
    s_valid = 1'b0;
    do @(negedge clk); while (!s_done);
    lat_slow = cyc - t0;
    check(lat_slow - lat_fast == D_SLOW - D_FAST, "R8 latency delta",
          lat_slow - lat_fast, D_SLOW - D_FAST);
    check(s_rdata == '0, "R7 slow read", s_rdata, 0);

    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule